// File: doc/BRIEF.md
# Bidirectional Strobed Port Controller

This block runs one byte-wide peripheral port as a two-way handshaked channel. A single set of tri-stateable pins carries two independent paths. The outbound path has an output latch that the host fills with a write. The latch reaches the pins only while the peripheral holds its acknowledge line low. The inbound path has an input latch that the peripheral loads with a low-going strobe, for the host to read later.

Five handshake lines report the state of the two paths: an active-low output-buffer-full flag, the acknowledge input, the strobe input, an input-buffer-full flag and one interrupt request. Each direction has its own request flag, and the host sets an enable bit for each one. The interrupt line is high when any enabled request is pending. A status byte puts the flags and both enables into fixed bit positions. Its three low bits pass through the status of the neighbouring port group, which lives outside this block.

All inputs are sampled on the rising edge of `clk`. The active-low strobe lines (`host_wr_n`, `host_rd_n`, `ack_n`, `stb_n`) are edge-detected against their value in the previous cycle. Reset and a mode-entry pulse return both paths to idle.

Top module: `bidir_strobe_port`

## Requirements
- R1: After `rst` or a `mode_enter` pulse, `obf_n` is 1, `ibf` is 0, `intr` is 0 and `pin_oe` is 0 (`pin_oe` returns to 0 only on `rst`; `mode_enter` clears the flags).
- R2: On the rising edge of `host_wr_n`, the output latch loads `host_wdata` and `obf_n` goes to 0 at that same clock edge. `pin_oe` stays 0 while `ack_n` is high.
- R3: From the clock edge after `ack_n` is seen low, `pin_oe` is 1 and `pin_out` equals the output latch. From the clock edge after `ack_n` is seen high, `pin_oe` is 0.
- R4: On the falling edge of `ack_n`, `obf_n` returns to 1, unless a write completes in the same cycle, in which case the write wins.
- R5: On the falling edge of `stb_n`, `ibf` goes to 1. In every cycle that `stb_n` is low, the input latch loads `pin_in`. `host_rdata` always presents the input latch.
- R6: On the rising edge of `host_rd_n`, `ibf` goes to 0. The input latch keeps its value.
- R7: The rising edge of `ack_n` sets the output request. The falling edge of `host_wr_n` clears it. The request reaches `intr` only while `inte_out` is 1.
- R8: The rising edge of `stb_n` sets the input request if `ibf` is 1. The falling edge of `host_rd_n` clears it. The request reaches `intr` only while `inte_in` is 1.
- R9: `intr` is the OR of both gated requests. Clearing one request leaves `intr` high while the other, enabled, request is still pending.
- R10: `status` bit 7 is `obf_n`, bit 6 is `inte_out`, bit 5 is `ibf`, bit 4 is `inte_in`, bit 3 is `intr`, and bits 2..0 equal `grp_b_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_enter | input | 1 | One-cycle pulse that clears both handshake paths |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wdata | input | DATA_W | Byte written by the host |
| host_rdata | output | DATA_W | Contents of the input latch |
| inte_out | input | 1 | Interrupt enable for the outbound path |
| inte_in | input | 1 | Interrupt enable for the inbound path |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| stb_n | input | 1 | Peripheral strobe, active low |
| pin_in | input | DATA_W | Pin data seen from outside |
| pin_out | output | DATA_W | Output latch toward the pins |
| pin_oe | output | 1 | Pin driver enable |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Combined interrupt request |
| grp_b_low | input | 3 | Neighbouring group's status bits |
| status | output | 8 | Packed status byte |

## Verification
Every byte value from 0 to 255 goes through a full outbound cycle (write, then an acknowledge pulse) and a full inbound cycle (strobe, then read). A stuck or swapped data bit therefore shows up at `pin_out` or `host_rdata`. The low two bits of the byte pick the enable pair, so every enable combination is tried many times. This separates a request that is not gated from one that is gated by the wrong enable. The low three bits also drive the passed-through status field, which exposes any misplaced status bit. Separate sequences leave both requests pending, then clear them one at a time, to show that the OR keeps `intr` high. A write that completes in the same cycle as an acknowledge fall is also tried, to check which of the two wins.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int STAT_W  = 8;
    localparam int LOW_W   = 3;
    localparam int LINE_CNT = 4;

    // index of each active-low strobe line in the edge bank
    typedef enum logic [1:0] {
        LN_WR  = 2'd0,
        LN_RD  = 2'd1,
        LN_ACK = 2'd2,
        LN_STB = 2'd3
    } line_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic obf_n;
        logic ibf;
        logic out_req;
        logic in_req;
    } flags_t;

    localparam flags_t FLAGS_IDLE = '{obf_n: 1'b1, ibf: 1'b0, out_req: 1'b0, in_req: 1'b0};

    // status byte layout: fixed, read by host software
    function automatic logic [STAT_W-1:0] pack_status(
        input flags_t          f,
        input logic            en_out,
        input logic            en_in,
        input logic            irq,
        input logic [LOW_W-1:0] low
    );
        return {f.obf_n, en_out, f.ibf, en_in, irq, low};
    endfunction

endpackage

// File: rtl/bsp_edge_bank.sv
module bsp_edge_bank
    import bsp_pkg::*;
#(
    parameter int N = LINE_CNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines_n,
    output edge_t        edges [N]
);

    logic [N-1:0] prev_n;

    always_ff @(posedge clk) begin
        if (rst) prev_n <= '1;
        else     prev_n <= lines_n;
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        always_comb begin
            edges[g].rise = ~prev_n[g] &  lines_n[g];
            edges[g].fall =  prev_n[g] & ~lines_n[g];
        end
    end

endmodule

// File: rtl/bsp_out_path.sv
module bsp_out_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_rise,
    input  logic              wr_fall,
    input  logic              ack_rise,
    input  logic              ack_fall,
    input  logic              ack_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] latch,
    output logic              obf_n,
    output logic              out_req,
    output logic              drive
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch <= '0;
            drive <= 1'b0;
        end else begin
            drive <= ~ack_n;
            if (wr_rise) latch <= wdata;
        end
    end

    // full flag: a completed write beats an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (rst || clr)    obf_n <= 1'b1;
        else if (wr_rise)  obf_n <= 1'b0;
        else if (ack_fall) obf_n <= 1'b1;
    end

    // request: cleared when the host starts the next write
    always_ff @(posedge clk) begin
        if (rst || clr)    out_req <= 1'b0;
        else if (wr_fall)  out_req <= 1'b0;
        else if (ack_rise) out_req <= 1'b1;
    end

endmodule

// File: rtl/bsp_in_path.sv
module bsp_in_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              stb_n,
    input  logic              stb_fall,
    input  logic              stb_rise,
    input  logic              rd_fall,
    input  logic              rd_rise,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] latch,
    output logic              ibf,
    output logic              in_req
);

    // latch is transparent while the strobe is held low
    always_ff @(posedge clk) begin
        if (rst)         latch <= '0;
        else if (!stb_n) latch <= pin_in;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)    ibf <= 1'b0;
        else if (stb_fall) ibf <= 1'b1;
        else if (rd_rise)  ibf <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)              in_req <= 1'b0;
        else if (rd_fall)            in_req <= 1'b0;
        else if (stb_rise && ibf)    in_req <= 1'b1;
    end

endmodule

// File: rtl/bsp_irq_merge.sv
module bsp_irq_merge #(
    parameter int SRC = 2
) (
    input  logic [SRC-1:0] req,
    input  logic [SRC-1:0] en,
    output logic           irq
);

    logic [SRC-1:0] gated;

    for (genvar g = 0; g < SRC; g++) begin : g_src
        assign gated[g] = req[g] & en[g];
    end

    assign irq = |gated;

endmodule

// File: rtl/bidir_strobe_port.sv
module bidir_strobe_port
    import bsp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_enter,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              inte_out,
    input  logic              inte_in,
    input  logic              ack_n,
    input  logic              stb_n,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic              pin_oe,
    output logic              obf_n,
    output logic              ibf,
    output logic              intr,
    input  logic [LOW_W-1:0]  grp_b_low,
    output logic [STAT_W-1:0] status
);

    localparam int IRQ_SRC = 2;

    logic [LINE_CNT-1:0] lines_n;
    edge_t               edges [LINE_CNT];
    flags_t              flags;

    always_comb begin
        lines_n         = '1;
        lines_n[LN_WR]  = host_wr_n;
        lines_n[LN_RD]  = host_rd_n;
        lines_n[LN_ACK] = ack_n;
        lines_n[LN_STB] = stb_n;
    end

    bsp_edge_bank #(.N(LINE_CNT)) i_edges (
        .clk     (clk),
        .rst     (rst),
        .lines_n (lines_n),
        .edges   (edges)
    );

    bsp_out_path #(.DATA_W(DATA_W)) i_out (
        .clk      (clk),
        .rst      (rst),
        .clr      (mode_enter),
        .wr_rise  (edges[LN_WR].rise),
        .wr_fall  (edges[LN_WR].fall),
        .ack_rise (edges[LN_ACK].rise),
        .ack_fall (edges[LN_ACK].fall),
        .ack_n    (ack_n),
        .wdata    (host_wdata),
        .latch    (pin_out),
        .obf_n    (flags.obf_n),
        .out_req  (flags.out_req),
        .drive    (pin_oe)
    );

    bsp_in_path #(.DATA_W(DATA_W)) i_in (
        .clk      (clk),
        .rst      (rst),
        .clr      (mode_enter),
        .stb_n    (stb_n),
        .stb_fall (edges[LN_STB].fall),
        .stb_rise (edges[LN_STB].rise),
        .rd_fall  (edges[LN_RD].fall),
        .rd_rise  (edges[LN_RD].rise),
        .pin_in   (pin_in),
        .latch    (host_rdata),
        .ibf      (flags.ibf),
        .in_req   (flags.in_req)
    );

    bsp_irq_merge #(.SRC(IRQ_SRC)) i_irq (
        .req ({flags.in_req, flags.out_req}),
        .en  ({inte_in, inte_out}),
        .irq (intr)
    );

    assign obf_n  = flags.obf_n;
    assign ibf    = flags.ibf;
    assign status = pack_status(flags, inte_out, inte_in, intr, grp_b_low);

endmodule

// File: rtl/bsp_checker.sv
module bsp_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_enter,
    input logic              host_wr_n,
    input logic              ack_n,
    input logic              stb_n,
    input logic              inte_out,
    input logic              inte_in,
    input logic [DATA_W-1:0] pin_in,
    input logic [DATA_W-1:0] host_rdata,
    input logic              pin_oe,
    input logic              obf_n,
    input logic              ibf,
    input logic              intr,
    input logic [2:0]        grp_b_low,
    input logic [7:0]        status
);

    logic c_wr_q, c_ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_wr_q  <= 1'b1;
            c_ack_q <= 1'b1;
        end else begin
            c_wr_q  <= host_wr_n;
            c_ack_q <= ack_n;
        end
    end

    wire c_wr_rise = !c_wr_q && host_wr_n;
    wire c_ack_fall = c_ack_q && !ack_n;

    AST_CLEAR_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        mode_enter |=> (obf_n && !ibf && !intr));                           // R1
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (c_wr_rise && !mode_enter) |=> !obf_n);                             // R2
    AST_FLOAT_ACK_HIGH: assert property (@(posedge clk) disable iff (rst)
        ack_n |=> !pin_oe);                                                 // R3
    AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (c_ack_fall && !c_wr_rise && !mode_enter) |=> obf_n);               // R4
    AST_STROBE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!stb_n && !mode_enter) |=> (host_rdata == $past(pin_in)));         // R5
    AST_INTR_GATED: assert property (@(posedge clk) disable iff (rst)
        intr |-> (inte_out || inte_in));                                    // R9
    AST_STATUS_LAYOUT: assert property (@(posedge clk) disable iff (rst)
        status == {obf_n, inte_out, ibf, inte_in, intr, grp_b_low});        // R10

endmodule

bind bidir_strobe_port bsp_checker #(.DATA_W(DATA_W)) i_bsp_checker (
    .clk        (clk),
    .rst        (rst),
    .mode_enter (mode_enter),
    .host_wr_n  (host_wr_n),
    .ack_n      (ack_n),
    .stb_n      (stb_n),
    .inte_out   (inte_out),
    .inte_in    (inte_in),
    .pin_in     (pin_in),
    .host_rdata (host_rdata),
    .pin_oe     (pin_oe),
    .obf_n      (obf_n),
    .ibf        (ibf),
    .intr       (intr),
    .grp_b_low  (grp_b_low),
    .status     (status)
);

// File: tb/test_bidir_strobe_port.sv
module test_bidir_strobe_port;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_enter = 1'b0;
    logic         host_wr_n = 1'b1, host_rd_n = 1'b1;
    logic [W-1:0] host_wdata = '0;
    logic [W-1:0] host_rdata;
    logic         inte_out = 1'b0, inte_in = 1'b0;
    logic         ack_n = 1'b1, stb_n = 1'b1;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic         pin_oe, obf_n, ibf, intr;
    logic [2:0]   grp_b_low = '0;
    logic [7:0]   status;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    bidir_strobe_port #(.DATA_W(W)) i_bidir_strobe_port (
        .clk(clk), .rst(rst), .mode_enter(mode_enter),
        .host_wr_n(host_wr_n), .host_rd_n(host_rd_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .inte_out(inte_out), .inte_in(inte_in),
        .ack_n(ack_n), .stb_n(stb_n), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .obf_n(obf_n), .ibf(ibf),
        .intr(intr), .grp_b_low(grp_b_low), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock step: edge, then settle at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_write(input logic [W-1:0] d);
        host_wdata = d; host_wr_n = 1'b0; step();
        host_wr_n = 1'b1; step();
    endtask

    task automatic host_read();
        host_rd_n = 1'b0; step();
        host_rd_n = 1'b1; step();
    endtask

    task automatic strobe(input logic [W-1:0] d);
        pin_in = d; stb_n = 1'b0; step();
        pin_in = ~d; stb_n = 1'b1; step();
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic exp_intr;
        @(negedge clk); step(); rst = 1'b0; step();
        chk("R1 obf_n", obf_n, 1); chk("R1 ibf", ibf, 0);
        chk("R1 intr", intr, 0);   chk("R1 pin_oe", pin_oe, 0);

        for (int v = 0; v < 256; v++) begin
            logic [W-1:0] d;
            d = W'(v);
            inte_out = d[0]; inte_in = d[1]; grp_b_low = d[2:0];
            host_write(d);
            chk("R2 obf_n low", obf_n, 0);
            chk("R2 pins float", pin_oe, 0);
            chk("R7 cleared by write", intr, 0);
            ack_n = 1'b0; step();
            chk("R3 drive", pin_oe, 1);
            chk("R3 data", pin_out, d);
            chk("R4 obf_n high", obf_n, 1);
            ack_n = 1'b1; step();
            chk("R3 float", pin_oe, 0);
            chk("R7 intr", intr, d[0]);
            host_write(~d);  // clears output request, leaves obf pending
            chk("R7 intr after write", intr, 0);
            ack_n = 1'b0; step(); ack_n = 1'b1; step();
            host_write(d);   // drop output request again
            strobe(d ^ 8'hA5);
            chk("R5 ibf", ibf, 1);
            chk("R5 data", host_rdata, d ^ 8'hA5);
            chk("R8 intr", intr, d[1]);
            chk("R10 status", status,
                {obf_n, d[0], 1'b1, d[1], d[1], d[2:0]});
            host_rd_n = 1'b0; step();
            chk("R8 cleared by read", intr, 0);
            host_rd_n = 1'b1; step();
            chk("R6 ibf clear", ibf, 0);
            chk("R6 data kept", host_rdata, d ^ 8'hA5);
        end

        // R9: both requests pending, clear them one at a time
        for (int e = 0; e < 4; e++) begin
            inte_out = e[0]; inte_in = e[1];
            host_write(8'h3C); ack_n = 1'b0; step(); ack_n = 1'b1; step();
            strobe(8'hC3);
            chk("R9 both", intr, e[0] | e[1]);
            host_read();
            chk("R9 out only", intr, e[0]);
            strobe(8'h5A);
            host_write(8'h11);
            exp_intr = e[1];
            chk("R9 in only", intr, exp_intr);
            host_read();
            chk("R9 none", intr, 0);
        end

        // R4: write completing in the same cycle as an ack fall wins
        host_wr_n = 1'b0; step();
        host_wr_n = 1'b1; ack_n = 1'b0; step();
        chk("R4 write wins", obf_n, 0);
        ack_n = 1'b1; step();

        // R1: mode entry clears flags and requests
        inte_out = 1'b1; inte_in = 1'b1;
        strobe(8'h77);
        chk("R1 pre ibf", ibf, 1);
        mode_enter = 1'b1; step(); mode_enter = 1'b0;
        chk("R1 entry obf_n", obf_n, 1);
        chk("R1 entry ibf", ibf, 0);
        chk("R1 entry intr", intr, 0);
        chk("R1 entry pin_oe", pin_oe, 0);

        summary();
    end

endmodule